// File: doc/BRIEF.md
# Universal Shift Register with Bidirectional Bus

This block is a W-bit register (eight bits by default) with four synchronous modes picked by a two-bit select: hold, shift toward the high end, shift toward the low end, and parallel load. One set of parallel pins works as the load input and also as the tri-state output. For synthesis, that pin set is split into three signals: a bus input, a bus output and a drive enable. An outside pad or bus fabric joins them.

Each shift direction has its own serial input. The two end bits are always on dedicated serial taps, so several instances can be chained into a longer word.

An active-low asynchronous reset clears the register. Two active-low output enables control the bus drivers. The drivers also switch off by themselves whenever load is selected. This lets the same pins carry data into the register without a bus conflict. Disabling the drivers never stops the register from shifting, holding, loading or clearing.

Top module: `ushift_bidir`

## Requirements
- R1: With `sel` = 2'b00 (hold), the register keeps its value across a rising clock edge.
- R2: With `sel` = 2'b01 (upshift), on a rising edge `ser_up_in` enters bit 0 and every bit n moves to bit n+1.
- R3: With `sel` = 2'b10 (downshift), on a rising edge `ser_dn_in` enters bit W-1 and every bit n moves to bit n-1.
- R4: With `sel` = 2'b11 (load), on a rising edge the register takes the value of `bus_in`.
- R5: While `rst_n` is low the register is all zeros. This takes effect at once, without a clock edge, and overrides `sel` and the clock.
- R6: `bus_drv` is 0 whenever either `oe_a_n` or `oe_b_n` is 1, or whenever `sel` = 2'b11. It is 1 only when both enables are 0 and `sel` is not 2'b11.
- R7: While `bus_drv` is 1, `bus_out` equals the register contents.
- R8: `tap_lo` always shows bit 0 and `tap_hi` always shows bit W-1, whatever the state of the enables and the select.
- R9: Hold, shifts, load and reset behave the same while the bus drivers are disabled.
- R10: Two instances chained in both directions shift a 2W-bit word correctly: `tap_hi` of the low instance feeds `ser_up_in` of the high one, and `tap_lo` of the high instance feeds `ser_dn_in` of the low one.
- R11: Changes on `sel`, the serial inputs or `bus_in` between clock edges leave the register unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge active |
| rst_n | input | 1 | Asynchronous clear, active low |
| sel | input | 2 | Mode select: 00 hold, 01 upshift, 10 downshift, 11 load |
| ser_up_in | input | 1 | Serial bit entering bit 0 on an upshift |
| ser_dn_in | input | 1 | Serial bit entering bit W-1 on a downshift |
| oe_a_n | input | 1 | Bus output enable A, active low |
| oe_b_n | input | 1 | Bus output enable B, active low |
| bus_in | input | W | Value read from the parallel pins |
| bus_out | output | W | Value to drive onto the parallel pins |
| bus_drv | output | 1 | Drive enable for the parallel pins |
| tap_lo | output | 1 | Bit 0, always driven |
| tap_hi | output | 1 | Bit W-1, always driven |

## Verification
Every mode result is due exactly one rising edge after the select and data are applied. The bench applies inputs just after a falling edge, updates its reference word on the rising edge, and compares on the following falling edge.

`bus_drv` and the taps are combinational from the inputs and the current register. They are compared in the same half-cycle as the inputs that produce them.

Reset is asserted halfway between edges and checked one time unit later, before any edge arrives. The between-edge test changes the inputs and checks the outputs again before the next rising edge, to show they have not moved.

// File: rtl/usr_pkg.sv
package usr_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_UP   = 2'b01,
        MODE_DN   = 2'b10,
        MODE_LOAD = 2'b11
    } usr_mode_e;

endpackage

// File: rtl/usr_mode_dec.sv
module usr_mode_dec
    import usr_pkg::*;
(
    input  logic [1:0] sel,
    input  logic       oe_a_n,
    input  logic       oe_b_n,
    output usr_mode_e  mode,
    output logic       drv
);

    always_comb begin
        unique case (sel)
            2'b00:   mode = MODE_HOLD;
            2'b01:   mode = MODE_UP;
            2'b10:   mode = MODE_DN;
            default: mode = MODE_LOAD;
        endcase
    end

    always_comb begin
        drv = 1'b0;
        if (!oe_a_n && !oe_b_n && (mode != MODE_LOAD))
            drv = 1'b1;
    end

endmodule

// File: rtl/usr_bit_cell.sv
module usr_bit_cell
    import usr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  usr_mode_e mode,
    input  logic      from_lo,
    input  logic      from_hi,
    input  logic      par_in,
    output logic      q
);

    logic q_nxt;

    always_comb begin
        unique case (mode)
            MODE_HOLD: q_nxt = q;
            MODE_UP:   q_nxt = from_lo;
            MODE_DN:   q_nxt = from_hi;
            MODE_LOAD: q_nxt = par_in;
            default:   q_nxt = q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= 1'b0;
        else
            q <= q_nxt;
    end

endmodule

// File: rtl/ushift_bidir.sv
module ushift_bidir
    import usr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   sel,
    input  logic         ser_up_in,
    input  logic         ser_dn_in,
    input  logic         oe_a_n,
    input  logic         oe_b_n,
    input  logic [W-1:0] bus_in,
    output logic [W-1:0] bus_out,
    output logic         bus_drv,
    output logic         tap_lo,
    output logic         tap_hi
);

    localparam int TOP = W - 1;

    usr_mode_e    mode;
    logic [W-1:0] q;
    logic [W-1:0] lo_src;
    logic [W-1:0] hi_src;

    usr_mode_dec u_dec (
        .sel    (sel),
        .oe_a_n (oe_a_n),
        .oe_b_n (oe_b_n),
        .mode   (mode),
        .drv    (bus_drv)
    );

    assign lo_src = {q[TOP-1:0], ser_up_in};
    assign hi_src = {ser_dn_in, q[TOP:1]};

    for (genvar i = 0; i < W; i++) begin : g_cell
        usr_bit_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .mode    (mode),
            .from_lo (lo_src[i]),
            .from_hi (hi_src[i]),
            .par_in  (bus_in[i]),
            .q       (q[i])
        );
    end

    always_comb begin
        bus_out = q;
        tap_lo  = q[0];
        tap_hi  = q[TOP];
    end

endmodule

// File: rtl/usr_chk.sv
module usr_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   sel,
    input logic         ser_up_in,
    input logic         ser_dn_in,
    input logic         oe_a_n,
    input logic         oe_b_n,
    input logic [W-1:0] bus_in,
    input logic [W-1:0] bus_out,
    input logic         bus_drv,
    input logic         tap_lo,
    input logic         tap_hi
);

    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b00) |=> (bus_out == $past(bus_out))); // R1

    AST_UP_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b01) |=> (bus_out == {$past(bus_out[W-2:0]), $past(ser_up_in)})); // R2

    AST_DN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b10) |=> (bus_out == {$past(ser_dn_in), $past(bus_out[W-1:1])})); // R3

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b11) |=> (bus_out == $past(bus_in))); // R4

    AST_RESET_CLEAR: assert property (@(posedge clk)
        (!rst_n) |-> (bus_out == '0)); // R5

    AST_NO_DRV_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b11) |-> !bus_drv); // R6

    AST_NO_DRV_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_a_n || oe_b_n) |-> !bus_drv); // R6

    AST_TAPS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_lo == bus_out[0]) && (tap_hi == bus_out[W-1])); // R8

endmodule

bind ushift_bidir usr_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .ser_up_in (ser_up_in),
    .ser_dn_in (ser_dn_in),
    .oe_a_n    (oe_a_n),
    .oe_b_n    (oe_b_n),
    .bus_in    (bus_in),
    .bus_out   (bus_out),
    .bus_drv   (bus_drv),
    .tap_lo    (tap_lo),
    .tap_hi    (tap_hi)
);

// File: tb/sim_ushift_bidir.sv
`timescale 1ns/1ps
module sim_ushift_bidir;

    localparam int W      = 8;
    localparam int CLK_NS = 10;
    localparam int LIMIT  = 5000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b1;
    logic [1:0]   sel = 2'b00;
    logic         sr_in = 1'b0;
    logic         sl_in = 1'b0;
    logic         oea = 1'b0;
    logic         oeb = 1'b0;
    logic [W-1:0] bin0 = '0;
    logic [W-1:0] bin1 = '0;

    logic [W-1:0] out0, out1;
    logic         drv0, drv1, lo0, hi0, lo1, hi1;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    logic [2*W-1:0] ref_word;
    logic [1:0]     last_sel;
    bit             last_oe_off;

    always #(CLK_NS/2) clk = ~clk;

    // Low half of a 2W-bit chain (R10)
    ushift_bidir #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .sel(sel), .ser_up_in(sr_in), .ser_dn_in(lo1),
        .oe_a_n(oea), .oe_b_n(oeb), .bus_in(bin0), .bus_out(out0), .bus_drv(drv0),
        .tap_lo(lo0), .tap_hi(hi0)
    );

    // High half of the chain
    ushift_bidir #(.W(W)) u1 (
        .clk(clk), .rst_n(rst_n), .sel(sel), .ser_up_in(hi0), .ser_dn_in(sl_in),
        .oe_a_n(oea), .oe_b_n(oeb), .bus_in(bin1), .bus_out(out1), .bus_drv(drv1),
        .tap_lo(lo1), .tap_hi(hi1)
    );

    // Behavioural reference of the whole 2W-bit word
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_word <= '0;
        end else begin
            last_sel    <= sel;
            last_oe_off <= oea || oeb;
            case (sel)
                2'b00: ref_word <= ref_word;
                2'b01: ref_word <= {ref_word[2*W-2:0], sr_in};
                2'b10: ref_word <= {sl_in, ref_word[2*W-1:1]};
                default: ref_word <= {bin1, bin0};
            endcase
        end
    end

    function automatic string tag_of(input logic [1:0] s, input bit off);
        string t;
        case (s)
            2'b00:   t = "R1";
            2'b01:   t = "R2/R10";
            2'b10:   t = "R3/R10";
            default: t = "R4";
        endcase
        if (off) t = {t, "+R9"};
        return t;
    endfunction

    task automatic check_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison on the falling edge
    always @(negedge clk) begin
        if (rst_n && !done && cycles > 1) begin
            check_eq(tag_of(last_sel, last_oe_off), {out1, out0}, ref_word);
            check_eq("R8", {lo0, hi0, lo1, hi1},
                     {ref_word[0], ref_word[W-1], ref_word[W], ref_word[2*W-1]});
            check_eq("R6", {drv0, drv1}, {2{!oea && !oeb && (sel != 2'b11)}});
            if (drv0) check_eq("R7", out0, ref_word[W-1:0]);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > LIMIT && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, LIMIT);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic drive(input logic [1:0] s, input logic r, input logic l,
                         input logic [W-1:0] b0, input logic [W-1:0] b1);
        @(negedge clk);
        #1;
        sel = s; sr_in = r; sl_in = l; bin0 = b0; bin1 = b1;
    endtask

    initial begin
        #2 rst_n = 1'b0;
        #1;
        check_eq("R5 reset state", {out1, out0}, 0);
        repeat (2) @(negedge clk);
        #1 rst_n = 1'b1;

        // Load with drivers enabled: drivers must drop during load (R6)
        drive(2'b11, 0, 0, 8'h34, 8'h12);
        #1 check_eq("R6 load disables drive", {drv0, drv1}, 2'b00);
        for (int i = 0; i < 3; i++) drive(2'b00, 1, 1, 8'hFF, 8'hFF);       // R1
        for (int i = 0; i < 2*W; i++) drive(2'b01, i[0] ^ i[2], 0, '0, '0);  // R2 R10
        drive(2'b11, 0, 0, 8'hC3, 8'h5A);                                    // R4
        for (int i = 0; i < 2*W; i++) drive(2'b10, 0, i[1], '0, '0);         // R3 R10

        // Drivers disabled by either enable (R9)
        oea = 1'b1;
        drive(2'b11, 0, 0, 8'h81, 8'h7E);
        drive(2'b01, 1, 0, '0, '0);
        oea = 1'b0; oeb = 1'b1;
        drive(2'b10, 0, 1, '0, '0);
        drive(2'b00, 0, 0, '0, '0);
        oeb = 1'b0;
        drive(2'b00, 0, 0, '0, '0);

        // Between-edge changes have no effect (R11)
        @(negedge clk);
        #1 sel = 2'b11; bin0 = 8'hAA; bin1 = 8'h55;
        #2 check_eq("R11 mid-cycle inputs", {out1, out0}, ref_word);
        sel = 2'b00;
        drive(2'b00, 0, 0, '0, '0);

        // Asynchronous reset between edges, select asking for load (R5)
        drive(2'b11, 0, 0, 8'hF0, 8'h0F);
        drive(2'b11, 0, 0, 8'hEE, 8'hDD);
        #1 rst_n = 1'b0;
        #1 check_eq("R5 async clear", {out1, out0}, 0);
        @(posedge clk);
        #1 check_eq("R5 reset overrides clock", {out1, out0}, 0);
        @(negedge clk);
        #1 rst_n = 1'b1;
        drive(2'b01, 1, 0, '0, '0);
        drive(2'b00, 0, 0, '0, '0);
        drive(2'b00, 0, 0, '0, '0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule